// File: doc/BRIEF.md
# Expansion bus cycle generator

This block drives a single chip select of a memory-mapped parallel expansion bus. A host-side request port accepts one read or write at a time. Each request carries an address, write data, two byte enables and a direction. The block expands each request into an external bus cycle. That cycle walks through five phases in a fixed order: address, chip-select setup, strobe, hold and recovery. Each phase lasts one clock plus a programmed extension.

Configuration inputs set several things. They set the five phase extensions and pick one of three strobe styles: separate read/write strobes, a single data strobe with a direction line, or a host-port cycle that also waits for an external ready signal. They also set the polarity of that ready signal, the data width (16-bit, or 8-bit on the low lane), whether byte reads may reach a halfword device, whether the address is multiplexed onto the data lines, and whether writes are permitted at all. The configuration is captured when a request is accepted, so each cycle runs with the settings that were present at its acceptance. When a cycle completes, the block returns read data together with a one-clock done pulse.

Top module: `exbus_cycle_gen`

## Requirements
- R1: After reset, req_ready is 1, rsp_done is 0, bus_cs_n, bus_rd_n, bus_wr_n and bus_ds_n are 1, bus_rnw is 1, bus_ale and bus_d_oe are 0, bus_be_n is 2'b11, rsp_rdata is 0 and err_cfg is 0.
- R2: Count clocks from the one after acceptance. With extensions A, S, T, H and R, bus_cs_n stays high for A+1 clocks (address phase). It is then low for (S+1)+(T+1+W)+(H+1) clocks, where W is the number of ready wait clocks. It is then high for R+1 recovery clocks. rsp_done is high for exactly one clock, the clock after recovery. A, S and H are 2-bit fields; T and R are 4-bit fields.
- R3: The active strobe goes low S+1 clocks after bus_cs_n falls. It stays low for T+1+W clocks, and it is only ever low while bus_cs_n is low.
- R4: Cycle type 0 (separate strobes) drives bus_rd_n low for reads and bus_wr_n low for writes. In this type bus_ds_n and bus_rnw stay 1. At most one strobe is low at any time.
- R5: Cycle types 1 (data strobe) and 2 (host port) drive bus_ds_n low in the strobe phase, and bus_rd_n and bus_wr_n stay 1. For a write cycle, bus_rnw is 0 on every busy clock.
- R6: In cycle type 2, the strobe phase lasts at least T+1 clocks and then continues until ready is active. Ready is active when bus_rdy equals cfg_rdy_high. Cycle types 0 and 1 ignore bus_rdy.
- R7: When cfg_wr_en is 0 at acceptance, a write drives no strobe and never enables the data drivers. The write still runs every phase and still ends with rsp_done.
- R8: For a read, rsp_rdata takes the bus data seen on the last clock of the strobe phase. rsp_rdata holds that value through later write cycles.
- R9: In byte mode (cfg_byte_bus=1), only data bits [7:0] are used and bus_be_n is 2'b10. If req_be is 2'b10, the high byte is selected: bus_addr[0] is 1, bus_d_out[7:0] carries req_wdata[15:8], and read data is returned in rsp_rdata[15:8] with the low byte zero. Any other req_be value selects the low byte, with bus_addr[0]=0 and the upper lanes zero.
- R10: On the 16-bit bus, a write drives bus_be_n = ~req_be. A read drives bus_be_n = ~req_be only when cfg_byte_rd_ok is 1 and req_be is 2'b01 or 2'b10; otherwise the read drives bus_be_n = 2'b00, a full halfword. Outside a cycle bus_be_n is 2'b11.
- R11: With cfg_mux_ad=1, every address-phase clock has bus_ale=1, bus_d_oe=1 and bus_d_out equal to the request address. With cfg_mux_ad=0, bus_ale stays 0 and the data lines are not driven during the address phase. Write data is driven from setup through hold.
- R12: Cycle type 3 runs as cycle type 0. Accepting a request with cycle type 3 sets err_cfg from the next clock, and err_cfg stays set until reset.
- R13: req_ready is 1 only when no cycle is in progress. Configuration inputs that change after acceptance do not affect the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | BUS_W | Write data |
| req_be | input | 2 | Byte enables, bit 1 = high byte |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | BUS_W | Last read data |
| cfg_t_addr | input | 2 | Address phase extension |
| cfg_t_setup | input | 2 | Setup phase extension |
| cfg_t_strobe | input | 4 | Strobe phase extension |
| cfg_t_hold | input | 2 | Hold phase extension |
| cfg_t_recov | input | 4 | Recovery phase extension |
| cfg_cycle_type | input | 2 | 0 split strobes, 1 data strobe, 2 host port, 3 illegal |
| cfg_byte_rd_ok | input | 1 | Allow byte reads on 16-bit bus |
| cfg_rdy_high | input | 1 | Ready active-high when 1 |
| cfg_mux_ad | input | 1 | Address on data lines during address phase |
| cfg_wr_en | input | 1 | Permit write strobes |
| cfg_byte_bus | input | 1 | 8-bit bus on low lane |
| err_cfg | output | 1 | Sticky illegal cycle-type flag |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rnw | output | 1 | Direction, 1 = read |
| bus_ale | output | 1 | Address valid on data lines |
| bus_be_n | output | 2 | Byte lane enables, active low |
| bus_d_out | output | BUS_W | Data lines out |
| bus_d_oe | output | 1 | Data line drive enable |
| bus_d_in | input | BUS_W | Data lines in |
| bus_rdy | input | 1 | External ready |

## Verification
The bench builds the block with its default parameters: ADDR_W=16 and BUS_W=16. The 16-bit bus brings both byte lanes within reach, so the bench can exercise byte mode, byte reads on the halfword bus, and lane selection side by side. Every combination of the 2-bit address, setup and hold extensions is applied, crossed with minimum, middle and maximum strobe extensions and minimum and maximum recovery extensions. The bench predicts each phase boundary, strobe window, wait length and sampled data value arithmetically from those settings. All four cycle-type codes are then crossed with direction, write permission, multiplexing, ready polarity and early or late ready.

// File: rtl/exbus_pkg.sv
package exbus_pkg;

    localparam int SHORT_EXT_W = 2;
    localparam int LONG_EXT_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ADDR   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4,
        PH_RECOV  = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        CT_SPLIT   = 2'd0,
        CT_DSTROBE = 2'd1,
        CT_HOST    = 2'd2,
        CT_BAD     = 2'd3
    } cyc_e;

    typedef struct packed {
        logic [SHORT_EXT_W-1:0] t_addr;
        logic [SHORT_EXT_W-1:0] t_setup;
        logic [LONG_EXT_W-1:0]  t_strobe;
        logic [SHORT_EXT_W-1:0] t_hold;
        logic [LONG_EXT_W-1:0]  t_recov;
    } timing_t;

endpackage

// File: rtl/exbus_phase_seq.sv
module exbus_phase_seq
    import exbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  timing_t tim,
    input  logic    hold_for_rdy,
    input  logic    rdy_ok,
    output phase_e  phase,
    output logic    strobe_last,
    output logic    done
);

    typedef struct packed {
        phase_e                ph;
        logic [LONG_EXT_W-1:0] cnt;
        logic                  done;
    } seq_t;

    seq_t s_q, s_d;
    logic cnt_zero;

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        strobe_last = 1'b0;
        cnt_zero    = (s_q.cnt == '0);
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph  = PH_ADDR;
                    s_d.cnt = LONG_EXT_W'(tim.t_addr);
                end
            end
            PH_ADDR: begin
                if (!cnt_zero) begin
                    s_d.cnt = s_q.cnt - LONG_EXT_W'(1);
                end else begin
                    s_d.ph  = PH_SETUP;
                    s_d.cnt = LONG_EXT_W'(tim.t_setup);
                end
            end
            PH_SETUP: begin
                if (!cnt_zero) begin
                    s_d.cnt = s_q.cnt - LONG_EXT_W'(1);
                end else begin
                    s_d.ph  = PH_STROBE;
                    s_d.cnt = tim.t_strobe;
                end
            end
            PH_STROBE: begin
                if (!cnt_zero) begin
                    s_d.cnt = s_q.cnt - LONG_EXT_W'(1);
                end else if (!hold_for_rdy || rdy_ok) begin
                    strobe_last = 1'b1;
                    s_d.ph      = PH_HOLD;
                    s_d.cnt     = LONG_EXT_W'(tim.t_hold);
                end
            end
            PH_HOLD: begin
                if (!cnt_zero) begin
                    s_d.cnt = s_q.cnt - LONG_EXT_W'(1);
                end else begin
                    s_d.ph  = PH_RECOV;
                    s_d.cnt = tim.t_recov;
                end
            end
            PH_RECOV: begin
                if (!cnt_zero) begin
                    s_d.cnt = s_q.cnt - LONG_EXT_W'(1);
                end else begin
                    s_d.ph   = PH_IDLE;
                    s_d.cnt  = '0;
                    s_d.done = 1'b1;
                end
            end
            default: begin
                s_d.ph  = PH_IDLE;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.ph;
    assign done  = s_q.done;

endmodule

// File: rtl/exbus_lane_map.sv
module exbus_lane_map #(
    parameter int ADDR_W = 16,
    parameter int BUS_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [1:0]        be,
    input  logic              write,
    input  logic              byte_bus,
    input  logic              byte_rd_ok,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        be_n,
    output logic [BUS_W-1:0]  wdata_bus,
    output logic [BUS_W-1:0]  rdata
);

    localparam int LANE_W = BUS_W / 2;

    logic hi_sel;
    logic single_lane;

    always_comb begin
        hi_sel      = (be == 2'b10);
        single_lane = (be == 2'b01) || (be == 2'b10);
        if (byte_bus) begin
            bus_addr  = {addr[ADDR_W-1:1], hi_sel};
            be_n      = 2'b10;
            wdata_bus = {{LANE_W{1'b0}},
                         hi_sel ? wdata[BUS_W-1:LANE_W] : wdata[LANE_W-1:0]};
            rdata     = hi_sel ? {bus_rdata[LANE_W-1:0], {LANE_W{1'b0}}}
                               : {{LANE_W{1'b0}}, bus_rdata[LANE_W-1:0]};
        end else begin
            bus_addr  = addr;
            wdata_bus = wdata;
            rdata     = bus_rdata;
            if (write || (byte_rd_ok && single_lane)) begin
                be_n = ~be;
            end else begin
                be_n = 2'b00;
            end
        end
    end

endmodule

// File: rtl/exbus_strobe_gen.sv
module exbus_strobe_gen
    import exbus_pkg::*;
(
    input  phase_e phase,
    input  cyc_e   ctype,
    input  logic   is_write,
    input  logic   wr_ok,
    input  logic   mux,
    output logic   cs_n,
    output logic   rd_n,
    output logic   wr_n,
    output logic   ds_n,
    output logic   rnw,
    output logic   ale,
    output logic   d_oe
);

    logic busy;
    logic in_cs;
    logic strobe_on;
    logic split;

    always_comb begin
        busy      = (phase != PH_IDLE);
        in_cs     = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        strobe_on = (phase == PH_STROBE) && (!is_write || wr_ok);
        split     = (ctype == CT_SPLIT);
        cs_n      = !in_cs;
        rd_n      = !(strobe_on && split && !is_write);
        wr_n      = !(strobe_on && split && is_write);
        ds_n      = !(strobe_on && !split);
        rnw       = !(busy && is_write && !split);
        ale       = (phase == PH_ADDR) && mux;
        d_oe      = ale || (in_cs && is_write && wr_ok);
    end

endmodule

// File: rtl/exbus_cycle_gen.sv
module exbus_cycle_gen
    import exbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BUS_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [BUS_W-1:0]       req_wdata,
    input  logic [1:0]             req_be,
    output logic                   rsp_done,
    output logic [BUS_W-1:0]       rsp_rdata,
    input  logic [SHORT_EXT_W-1:0] cfg_t_addr,
    input  logic [SHORT_EXT_W-1:0] cfg_t_setup,
    input  logic [LONG_EXT_W-1:0]  cfg_t_strobe,
    input  logic [SHORT_EXT_W-1:0] cfg_t_hold,
    input  logic [LONG_EXT_W-1:0]  cfg_t_recov,
    input  logic [1:0]             cfg_cycle_type,
    input  logic                   cfg_byte_rd_ok,
    input  logic                   cfg_rdy_high,
    input  logic                   cfg_mux_ad,
    input  logic                   cfg_wr_en,
    input  logic                   cfg_byte_bus,
    output logic                   err_cfg,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic                   bus_cs_n,
    output logic                   bus_rd_n,
    output logic                   bus_wr_n,
    output logic                   bus_ds_n,
    output logic                   bus_rnw,
    output logic                   bus_ale,
    output logic [1:0]             bus_be_n,
    output logic [BUS_W-1:0]       bus_d_out,
    output logic                   bus_d_oe,
    input  logic [BUS_W-1:0]       bus_d_in,
    input  logic                   bus_rdy
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  wdata;
        logic [1:0]        be;
        logic              write;
        timing_t           tim;
        cyc_e              ctype;
        logic              byte_rd_ok;
        logic              rdy_high;
        logic              mux;
        logic              wr_ok;
        logic              byte_bus;
        logic [BUS_W-1:0]  rdata;
        logic              err;
    } state_t;

    state_t r_q, r_d;

    phase_e            phase;
    logic              strobe_last;
    logic              seq_done;
    timing_t           cfg_tim;
    timing_t           seq_tim;
    logic              accept;
    logic              rdy_ok;
    logic [ADDR_W-1:0] map_addr;
    logic [1:0]        map_be_n;
    logic [BUS_W-1:0]  map_wdata;
    logic [BUS_W-1:0]  map_rdata;

    always_comb begin
        cfg_tim = '{t_addr:   cfg_t_addr,
                    t_setup:  cfg_t_setup,
                    t_strobe: cfg_t_strobe,
                    t_hold:   cfg_t_hold,
                    t_recov:  cfg_t_recov};
        accept  = req_valid && (phase == PH_IDLE);
        seq_tim = accept ? cfg_tim : r_q.tim;
        rdy_ok  = r_q.rdy_high ? bus_rdy : !bus_rdy;

        r_d = r_q;
        if (accept) begin
            r_d.addr       = req_addr;
            r_d.wdata      = req_wdata;
            r_d.be         = req_be;
            r_d.write      = req_write;
            r_d.tim        = cfg_tim;
            r_d.byte_rd_ok = cfg_byte_rd_ok;
            r_d.rdy_high   = cfg_rdy_high;
            r_d.mux        = cfg_mux_ad;
            r_d.wr_ok      = cfg_wr_en;
            r_d.byte_bus   = cfg_byte_bus;
            if (cfg_cycle_type == CT_BAD) begin
                r_d.ctype = CT_SPLIT;
                r_d.err   = 1'b1;
            end else begin
                r_d.ctype = cyc_e'(cfg_cycle_type);
            end
        end
        if (strobe_last && !r_q.write) begin
            r_d.rdata = map_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    exbus_phase_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (accept),
        .tim          (seq_tim),
        .hold_for_rdy (r_q.ctype == CT_HOST),
        .rdy_ok       (rdy_ok),
        .phase        (phase),
        .strobe_last  (strobe_last),
        .done         (seq_done)
    );

    exbus_lane_map #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W)
    ) u_lane (
        .addr       (r_q.addr),
        .wdata      (r_q.wdata),
        .be         (r_q.be),
        .write      (r_q.write),
        .byte_bus   (r_q.byte_bus),
        .byte_rd_ok (r_q.byte_rd_ok),
        .bus_rdata  (bus_d_in),
        .bus_addr   (map_addr),
        .be_n       (map_be_n),
        .wdata_bus  (map_wdata),
        .rdata      (map_rdata)
    );

    exbus_strobe_gen u_strb (
        .phase    (phase),
        .ctype    (r_q.ctype),
        .is_write (r_q.write),
        .wr_ok    (r_q.wr_ok),
        .mux      (r_q.mux),
        .cs_n     (bus_cs_n),
        .rd_n     (bus_rd_n),
        .wr_n     (bus_wr_n),
        .ds_n     (bus_ds_n),
        .rnw      (bus_rnw),
        .ale      (bus_ale),
        .d_oe     (bus_d_oe)
    );

    assign req_ready = (phase == PH_IDLE);
    assign rsp_done  = seq_done;
    assign rsp_rdata = r_q.rdata;
    assign err_cfg   = r_q.err;
    assign bus_addr  = map_addr;
    assign bus_be_n  = (phase == PH_IDLE) ? 2'b11 : map_be_n;
    assign bus_d_out = bus_ale ? BUS_W'(r_q.addr) : map_wdata;

endmodule

// File: rtl/exbus_cycle_gen_chk.sv
module exbus_cycle_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_done,
    input logic err_cfg,
    input logic bus_cs_n,
    input logic bus_rd_n,
    input logic bus_wr_n,
    input logic bus_ds_n,
    input logic bus_ale,
    input logic bus_d_oe
);

    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!bus_rd_n, !bus_wr_n, !bus_ds_n}));

    // R3
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n || !bus_ds_n) |-> !bus_cs_n);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R13
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    // R13
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |-> !req_ready);

    // R11
    ale_outside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_cs_n && bus_d_oe && !req_ready));

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cfg |=> err_cfg);

endmodule

bind exbus_cycle_gen exbus_cycle_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .err_cfg   (err_cfg),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_ds_n  (bus_ds_n),
    .bus_ale   (bus_ale),
    .bus_d_oe  (bus_d_oe)
);

// File: tb/exbus_cycle_gen_test.sv
module exbus_cycle_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [1:0]  cfg_t_addr = '0;
    logic [1:0]  cfg_t_setup = '0;
    logic [3:0]  cfg_t_strobe = '0;
    logic [1:0]  cfg_t_hold = '0;
    logic [3:0]  cfg_t_recov = '0;
    logic [1:0]  cfg_cycle_type = '0;
    logic        cfg_byte_rd_ok = 1'b0;
    logic        cfg_rdy_high = 1'b0;
    logic        cfg_mux_ad = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_byte_bus = 1'b0;
    logic        err_cfg;
    logic [15:0] bus_addr;
    logic        bus_cs_n, bus_rd_n, bus_wr_n, bus_ds_n, bus_rnw, bus_ale;
    logic [1:0]  bus_be_n;
    logic [15:0] bus_d_out;
    logic        bus_d_oe;
    logic [15:0] bus_d_in = '0;
    logic        bus_rdy = 1'b1;

    int n_vec = 0;
    int n_bad = 0;

    // plan of the next transaction
    int p_wr, p_ct, p_a, p_s, p_t, p_h, p_r, p_w;
    int p_rdyh, p_mux, p_wen, p_bb, p_bro, p_addr, p_wdata, p_be;
    int err_model = 0;
    int last_rdata = 0;

    always #4 clk = ~clk;

    exbus_cycle_gen uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .cfg_t_addr(cfg_t_addr), .cfg_t_setup(cfg_t_setup), .cfg_t_strobe(cfg_t_strobe),
        .cfg_t_hold(cfg_t_hold), .cfg_t_recov(cfg_t_recov), .cfg_cycle_type(cfg_cycle_type),
        .cfg_byte_rd_ok(cfg_byte_rd_ok), .cfg_rdy_high(cfg_rdy_high), .cfg_mux_ad(cfg_mux_ad),
        .cfg_wr_en(cfg_wr_en), .cfg_byte_bus(cfg_byte_bus), .err_cfg(err_cfg),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_ds_n(bus_ds_n), .bus_rnw(bus_rnw), .bus_ale(bus_ale), .bus_be_n(bus_be_n),
        .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .bus_d_in(bus_d_in), .bus_rdy(bus_rdy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'(32'h5A3C + i * 291);
    endfunction

    task automatic run_txn();
        int wx, k, n_busy, st, ls, split, on, hi;
        int cs_first, cs_cnt, str_first, str_cnt, kind, rnw_cnt;
        int ale_cnt, ale_bad, oe_cnt, rdy_cnt, done_at;
        int s_be_n, s_addr, s_dout;
        int exp_be_n, exp_addr, exp_dout, exp_rd, d;
        split  = (p_ct == 0 || p_ct == 3) ? 1 : 0;
        wx     = (p_ct == 2 && p_w > 0) ? p_w : 0;
        n_busy = 5 + p_a + p_s + p_t + p_h + p_r + wx;
        st     = p_a + p_s + 3;
        k      = (p_ct == 2) ? st + p_t + p_w : 100000;
        on     = (p_wr == 0 || p_wen != 0) ? 1 : 0;
        hi     = (p_be == 2) ? 1 : 0;
        cs_first = 0; cs_cnt = 0; str_first = 0; str_cnt = 0; kind = 0; rnw_cnt = 0;
        ale_cnt = 0; ale_bad = 0; oe_cnt = 0; rdy_cnt = 0; done_at = 0;
        s_be_n = 0; s_addr = 0; s_dout = 0;

        @(negedge clk);
        req_write      = p_wr[0];
        req_addr       = 16'(p_addr);
        req_wdata      = 16'(p_wdata);
        req_be         = 2'(p_be);
        cfg_t_addr     = 2'(p_a);
        cfg_t_setup    = 2'(p_s);
        cfg_t_strobe   = 4'(p_t);
        cfg_t_hold     = 2'(p_h);
        cfg_t_recov    = 4'(p_r);
        cfg_cycle_type = 2'(p_ct);
        cfg_rdy_high   = p_rdyh[0];
        cfg_mux_ad     = p_mux[0];
        cfg_wr_en      = p_wen[0];
        cfg_byte_bus   = p_bb[0];
        cfg_byte_rd_ok = p_bro[0];
        bus_rdy        = p_rdyh[0] ? 1'b0 : 1'b1;
        req_valid      = 1'b1;
        #1;
        chk("R13 ready when idle", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        // R13: changing config after acceptance must not matter
        cfg_t_addr = 2'd3; cfg_t_setup = 2'd3; cfg_t_strobe = 4'd15;
        cfg_t_hold = 2'd3; cfg_t_recov = 4'd15;
        cfg_rdy_high = ~cfg_rdy_high; cfg_mux_ad = ~cfg_mux_ad;
        cfg_wr_en = ~cfg_wr_en; cfg_byte_bus = ~cfg_byte_bus;
        cfg_cycle_type = 2'(p_ct ^ 1);
        for (int i = 1; i < 400; i++) begin
            bus_rdy  = p_rdyh[0] ? (i >= k) : !(i >= k);
            bus_d_in = pat(i);
            #1;
            if (rsp_done) begin
                done_at = i;
                break;
            end
            if (req_ready) rdy_cnt++;
            if (!bus_cs_n) begin
                if (cs_first == 0) cs_first = i;
                cs_cnt++;
            end
            if (!bus_rd_n || !bus_wr_n || !bus_ds_n) begin
                if (str_first == 0) str_first = i;
                str_cnt++;
                kind = kind | ((!bus_rd_n) ? 4 : 0) | ((!bus_wr_n) ? 2 : 0) | ((!bus_ds_n) ? 1 : 0);
            end
            if (!bus_rnw) rnw_cnt++;
            if (bus_ale) begin
                ale_cnt++;
                if (!bus_d_oe || int'(bus_d_out) != p_addr) ale_bad++;
            end
            if (bus_d_oe) oe_cnt++;
            if (i == p_a + 2) begin
                s_be_n = int'(bus_be_n);
                s_addr = int'(bus_addr);
                s_dout = int'(bus_d_out);
            end
            @(negedge clk);
        end

        chk("R2 done clock", done_at, n_busy + 1);
        chk("R2 chip select falls after address phase", cs_first, p_a + 2);
        chk("R2 chip select low length", cs_cnt, p_s + p_t + wx + p_h + 3);
        chk("R13 no ready while busy", rdy_cnt, 0);
        chk("R3 R7 strobe start", str_first, on ? st : 0);
        chk("R3 R6 R7 strobe length", str_cnt, on ? p_t + 1 + wx : 0);
        chk("R4 R5 strobe kind", kind, on ? (split ? (p_wr ? 2 : 4) : 1) : 0);
        chk("R5 direction line", rnw_cnt, (p_wr != 0 && split == 0) ? n_busy : 0);
        chk("R11 address phase ale clocks", ale_cnt, p_mux ? p_a + 1 : 0);
        chk("R11 address on data lines", ale_bad, 0);
        chk("R7 R11 data drive clocks", oe_cnt,
            (p_mux ? p_a + 1 : 0) + ((p_wr != 0 && p_wen != 0) ? p_s + p_t + wx + p_h + 3 : 0));
        chk("R12 error flag", int'(err_cfg), err_model);

        if (p_bb != 0) exp_be_n = 2;
        else if (p_wr != 0) exp_be_n = (~p_be) & 3;
        else if (p_bro != 0 && (p_be == 1 || p_be == 2)) exp_be_n = (~p_be) & 3;
        else exp_be_n = 0;
        chk("R9 R10 byte enables", s_be_n, exp_be_n);
        exp_addr = (p_bb != 0) ? ((p_addr & 16'hFFFE) | hi) : p_addr;
        chk("R9 bus address", s_addr, exp_addr);
        if (p_wr != 0 && p_wen != 0) begin
            exp_dout = (p_bb != 0) ? (hi ? ((p_wdata >> 8) & 255) : (p_wdata & 255)) : p_wdata;
            chk("R9 write data lanes", s_dout, exp_dout);
        end
        if (p_wr == 0) begin
            ls = st + p_t + wx;
            d  = int'(pat(ls));
            if (p_bb != 0) exp_rd = hi ? ((d & 255) << 8) : (d & 255);
            else exp_rd = d;
            last_rdata = exp_rd;
        end
        chk("R8 R9 read data", int'(rsp_rdata), last_rdata);
        @(negedge clk);
        chk("R2 done is one clock", int'(rsp_done), 0);
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 done", int'(rsp_done), 0);
        chk("R1 strobes", int'({bus_cs_n, bus_rd_n, bus_wr_n, bus_ds_n, bus_rnw}), 31);
        chk("R1 ale and drive", int'({bus_ale, bus_d_oe}), 0);
        chk("R1 byte enables", int'(bus_be_n), 3);
        chk("R1 read data", int'(rsp_rdata), 0);
        chk("R1 error flag", int'(err_cfg), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", int'({req_ready, bus_cs_n}), 3);

        // timing sweep: every short extension, end values of long ones
        for (int a = 0; a < 4; a++)
            for (int s = 0; s < 4; s++)
                for (int h = 0; h < 4; h++)
                    for (int ti = 0; ti < 3; ti++)
                        for (int ri = 0; ri < 2; ri++) begin
                            p_a = a; p_s = s; p_h = h;
                            p_t = (ti == 0) ? 0 : ((ti == 1) ? 6 : 15);
                            p_r = (ri == 0) ? 0 : 15;
                            p_ct = (a + s + ti) % 3;
                            p_wr = h & 1; p_w = (s & 1) ? 2 : 0;
                            p_rdyh = a & 1; p_mux = (a ^ h) & 1; p_wen = 1;
                            p_bb = 0; p_bro = 0; p_be = 3;
                            p_addr = 16'h1230 + a * 64 + s * 16 + h;
                            p_wdata = 16'hC000 + ti * 256 + ri * 16 + a;
                            run_txn();
                        end

        // mode sweep: cycle type, direction, write permission, mux, ready
        for (int ct = 0; ct < 4; ct++)
            for (int wr = 0; wr < 2; wr++)
                for (int wen = 0; wen < 2; wen++)
                    for (int mx = 0; mx < 2; mx++)
                        for (int rh = 0; rh < 2; rh++) begin
                            p_ct = ct; p_wr = wr; p_wen = wen; p_mux = mx; p_rdyh = rh;
                            p_a = 1; p_s = 0; p_t = 2; p_h = 1; p_r = 1;
                            p_w = (mx != 0) ? 4 : -2;
                            p_bb = 0; p_bro = 0; p_be = 3;
                            p_addr = 16'h8A50 + ct; p_wdata = 16'h3C00 + wr * 16 + wen;
                            if (ct == 3) err_model = 1;
                            run_txn();
                        end

        // lane sweep: byte bus, byte reads, enables, address bit 0
        for (int bb = 0; bb < 2; bb++)
            for (int bro = 0; bro < 2; bro++)
                for (int wr = 0; wr < 2; wr++)
                    for (int be = 0; be < 4; be++)
                        for (int lsb = 0; lsb < 2; lsb++) begin
                            p_bb = bb; p_bro = bro; p_wr = wr; p_be = be;
                            p_ct = 1; p_wen = 1; p_mux = 0; p_rdyh = 0; p_w = 0;
                            p_a = 0; p_s = 1; p_t = 1; p_h = 0; p_r = 0;
                            p_addr = 16'h4440 + lsb; p_wdata = 16'hB700 + be * 17 + 16'h0009;
                            run_txn();
                        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule